// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is the host-side controller for a 16-bit successive-approximation converter with a parallel output. The converter is driven through four lines: an active-low chip select, a read/convert select, a reset line and an active-low end-of-conversion flag. A single user pulse starts one conversion. The controller then produces two chip-select falling edges. The first edge, with read/convert low, wakes the converter and opens the acquisition window. The second edge closes that window and starts the conversion. The level of read/convert at the second edge tells the converter whether to keep its reference powered afterwards (standby) or to power it down (shutdown).

After the second edge the controller waits for end-of-conversion to fall, with a timeout as a limit. It then reads the data bus with chip select low and read/convert high. It returns the word together with a one-cycle valid strobe. If the previous conversion left the reference off, the acquisition window is stretched to the reference wake-up time. Power-on, a reset command and a timeout all count as leaving the reference off. Every time value is given in nanoseconds or microseconds and converted to system-clock cycles at elaboration.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After rst_n is released the block is idle: adc_cs_n=1, adc_rc=0, adc_reset=0, busy=0, result_valid=0, eoc_timeout=0.
- R2: A sample_req seen while idle (and reset_cmd low) drives adc_cs_n low on the next cycle with adc_rc=0, and holds it low for exactly CS_LOW cycles.
- R3: When the reference was left on by the previous conversion (shutdown_sel=0), the second chip-select fall comes exactly CS_LOW+ACQ cycles after the first.
- R4: At the second chip-select fall, adc_rc equals the shutdown_sel value captured with the request (1 = shutdown, 0 = standby). Chip select then stays low for exactly CS_LOW cycles.
- R5: After power-on, a reset command, a timeout or a conversion with shutdown_sel=1, the gap between the two chip-select falls is exactly CS_LOW+WAKE cycles.
- R6: For any end-of-conversion delay shorter than the timeout, the block reads with adc_cs_n=0 and adc_rc=1 for exactly DV cycles. It then raises adc_cs_n and, in the same cycle, pulses result_valid for one cycle with result_data equal to the bus word.
- R7: If end-of-conversion does not fall within TMO cycles after the second chip-select low phase, eoc_timeout is set, no result_valid is given, and adc_cs_n returns high. The next accepted sample_req clears eoc_timeout.
- R8: busy is high from the cycle after an accepted request until the block is idle again. Requests made while busy start no extra chip-select sequence.
- R9: A reset_cmd seen while idle (it has priority over sample_req) drives adc_reset high for exactly RST cycles while adc_cs_n stays high.
- R10: result_data changes only in a cycle where result_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | Request one conversion (sampled when idle) |
| shutdown_sel | input | 1 | Power mode after this conversion: 1 shutdown, 0 standby |
| reset_cmd | input | 1 | Request a converter reset pulse (sampled when idle) |
| busy | output | 1 | Sequence or reset in progress |
| result_valid | output | 1 | One-cycle strobe for result_data |
| result_data | output | DATA_W | Last converted word |
| eoc_timeout | output | 1 | End-of-conversion did not arrive in time |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert select |
| adc_reset | output | 1 | Converter reset, active high |
| adc_eoc_n | input | 1 | Converter end-of-conversion, active low (asynchronous) |
| adc_data | input | DATA_W | Converter parallel data bus |

## Verification
If the power-mode flag is wrong, the next conversion shows it at once: the gap between its two chip-select falls is off by WAKE-ACQ cycles. A miscounted phase shows up as a chip-select low width one or more cycles off. A lost end-of-conversion event does not show until TMO cycles later, when eoc_timeout rises instead of the read phase appearing. A wrong capture point appears in the same cycle as result_valid, as a word that differs from the bus pattern.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_CS1,
        ST_ACQ,
        ST_CS2,
        ST_CONV,
        ST_GAP,
        ST_READ,
        ST_COOL
    } seq_state_e;

    // Round a time in ns up to whole clock cycles; never less than one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned t;
        t = (ns * mhz + 999) / 1000;
        if (t < 1) t = 1;
        return t;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    localparam int unsigned W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    // Oldest stage still high, synchronized level now low.
    assign fall = sh_q[W-1] & ~sh_q[W-2];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned CS_LOW_CYC  = 2,
    parameter int unsigned CS_HIGH_CYC = 2,
    parameter int unsigned ACQ_CYC     = 10,
    parameter int unsigned WAKE_CYC    = 50,
    parameter int unsigned TMO_CYC     = 100,
    parameter int unsigned DV_CYC      = 2,
    parameter int unsigned RST_CYC     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_req,
    input  logic              shutdown_sel,
    input  logic              reset_cmd,
    input  logic              eoc_fall,
    input  logic [DATA_W-1:0] bus_data,
    output logic              busy,
    output logic              result_valid,
    output logic [DATA_W-1:0] result_data,
    output logic              eoc_timeout,
    output logic              cs_n,
    output logic              rc,
    output logic              conv_rst
);
    localparam logic [CNT_W-1:0] LD_CS_LOW  = CNT_W'(CS_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CS_HIGH = CNT_W'(CS_HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACQ     = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WAKE    = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TMO     = CNT_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] LD_DV      = CNT_W'(DV_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RST     = CNT_W'(RST_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              shut;     // reference is off, wake wait needed
        logic              mode;     // power mode chosen for this conversion
        logic              eoc_hit;  // end-of-conversion seen early
        logic              cs_n;
        logic              rc;
        logic              rst_out;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t st_d, st_q;
    logic      cnt_done;

    assign cnt_done = (st_q.cnt == '0);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!cnt_done) st_d.cnt = st_q.cnt - CNT_W'(1);

        unique case (st_q.state)
            ST_IDLE: begin
                if (reset_cmd) begin
                    st_d.state   = ST_RST;
                    st_d.cnt     = LD_RST;
                    st_d.rst_out = 1'b1;
                    st_d.shut    = 1'b1;
                end else if (sample_req) begin
                    st_d.state = ST_CS1;
                    st_d.cnt   = LD_CS_LOW;
                    st_d.cs_n  = 1'b0;
                    st_d.rc    = 1'b0;
                    st_d.mode  = shutdown_sel;
                    st_d.err   = 1'b0;
                end
            end
            ST_RST: begin
                if (cnt_done) begin
                    st_d.state   = ST_COOL;
                    st_d.cnt     = LD_CS_HIGH;
                    st_d.rst_out = 1'b0;
                end
            end
            ST_CS1: begin
                if (cnt_done) begin
                    st_d.state = ST_ACQ;
                    st_d.cs_n  = 1'b1;
                    st_d.cnt   = st_q.shut ? LD_WAKE : LD_ACQ;
                end
            end
            ST_ACQ: begin
                if (cnt_done) begin
                    st_d.state   = ST_CS2;
                    st_d.cnt     = LD_CS_LOW;
                    st_d.cs_n    = 1'b0;
                    st_d.rc      = st_q.mode;
                    st_d.eoc_hit = 1'b0;
                end
            end
            ST_CS2: begin
                if (eoc_fall) st_d.eoc_hit = 1'b1;
                if (cnt_done) begin
                    st_d.state = ST_CONV;
                    st_d.cnt   = LD_TMO;
                    st_d.cs_n  = 1'b1;
                    st_d.rc    = 1'b0;
                    st_d.shut  = st_q.mode;
                end
            end
            ST_CONV: begin
                if (eoc_fall || st_q.eoc_hit) begin
                    st_d.state   = ST_GAP;
                    st_d.cnt     = LD_CS_HIGH;
                    st_d.eoc_hit = 1'b0;
                end else if (cnt_done) begin
                    st_d.state = ST_COOL;
                    st_d.cnt   = LD_CS_HIGH;
                    st_d.err   = 1'b1;
                    st_d.shut  = 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_done) begin
                    st_d.state = ST_READ;
                    st_d.cnt   = LD_DV;
                    st_d.cs_n  = 1'b0;
                    st_d.rc    = 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_done) begin
                    st_d.state = ST_COOL;
                    st_d.cnt   = LD_CS_HIGH;
                    st_d.cs_n  = 1'b1;
                    st_d.rc    = 1'b0;
                    st_d.data  = bus_data;
                    st_d.valid = 1'b1;
                end
            end
            ST_COOL: begin
                if (cnt_done) st_d.state = ST_IDLE;
            end
            default: begin
                st_d.state = ST_IDLE;
                st_d.cs_n  = 1'b1;
                st_d.rc    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state   <= ST_IDLE;
            st_q.cnt     <= '0;
            st_q.shut    <= 1'b1;
            st_q.mode    <= 1'b0;
            st_q.eoc_hit <= 1'b0;
            st_q.cs_n    <= 1'b1;
            st_q.rc      <= 1'b0;
            st_q.rst_out <= 1'b0;
            st_q.valid   <= 1'b0;
            st_q.err     <= 1'b0;
            st_q.data    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = (st_q.state != ST_IDLE);
    assign result_valid = st_q.valid;
    assign result_data  = st_q.data;
    assign eoc_timeout  = st_q.err;
    assign cs_n         = st_q.cs_n;
    assign rc           = st_q.rc;
    assign conv_rst     = st_q.rst_out;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CLK_MHZ     = 50,
    parameter int unsigned CS_LOW_NS   = 40,
    parameter int unsigned CS_HIGH_NS  = 40,
    parameter int unsigned ACQ_NS      = 1100,
    parameter int unsigned WAKE_US     = 12000,
    parameter int unsigned EOC_TMO_NS  = 10000,
    parameter int unsigned DV_NS       = 60,
    parameter int unsigned RST_NS      = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_req,
    input  logic              shutdown_sel,
    input  logic              reset_cmd,
    output logic              busy,
    output logic              result_valid,
    output logic [DATA_W-1:0] result_data,
    output logic              eoc_timeout,
    output logic              adc_cs_n,
    output logic              adc_rc,
    output logic              adc_reset,
    input  logic              adc_eoc_n,
    input  logic [DATA_W-1:0] adc_data
);
    localparam int unsigned CS_LOW_CYC  = ns_to_cyc(CS_LOW_NS, CLK_MHZ);
    localparam int unsigned CS_HIGH_CYC = ns_to_cyc(CS_HIGH_NS, CLK_MHZ);
    localparam int unsigned ACQ_RAW     = ns_to_cyc(ACQ_NS, CLK_MHZ);
    localparam int unsigned ACQ_CYC     = max2(ACQ_RAW, CS_HIGH_CYC);
    localparam int unsigned WAKE_CYC    = max2(WAKE_US * CLK_MHZ, ACQ_CYC);
    localparam int unsigned TMO_CYC     = ns_to_cyc(EOC_TMO_NS, CLK_MHZ);
    localparam int unsigned DV_CYC      = ns_to_cyc(DV_NS, CLK_MHZ);
    localparam int unsigned RST_CYC     = ns_to_cyc(RST_NS, CLK_MHZ);
    localparam int unsigned CNT_MAX     = max2(max2(WAKE_CYC, TMO_CYC),
                                               max2(max2(CS_LOW_CYC, DV_CYC), RST_CYC));
    localparam int unsigned CNT_W       = $clog2(CNT_MAX + 1);

    logic eoc_fall;

    adc_seq_sync #(
        .STAGES (SYNC_STAGES)
    ) u_eoc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_eoc_n),
        .fall  (eoc_fall)
    );

    adc_seq_fsm #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .CS_LOW_CYC  (CS_LOW_CYC),
        .CS_HIGH_CYC (CS_HIGH_CYC),
        .ACQ_CYC     (ACQ_CYC),
        .WAKE_CYC    (WAKE_CYC),
        .TMO_CYC     (TMO_CYC),
        .DV_CYC      (DV_CYC),
        .RST_CYC     (RST_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_req   (sample_req),
        .shutdown_sel (shutdown_sel),
        .reset_cmd    (reset_cmd),
        .eoc_fall     (eoc_fall),
        .bus_data     (adc_data),
        .busy         (busy),
        .result_valid (result_valid),
        .result_data  (result_data),
        .eoc_timeout  (eoc_timeout),
        .cs_n         (adc_cs_n),
        .rc           (adc_rc),
        .conv_rst     (adc_reset)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_req,
    input logic              reset_cmd,
    input logic              busy,
    input logic              result_valid,
    input logic [DATA_W-1:0] result_data,
    input logic              eoc_timeout,
    input logic              adc_cs_n,
    input logic              adc_rc,
    input logic              adc_reset
);
    AST_REQ_STARTS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_req && !reset_cmd && !busy) |=> (!adc_cs_n && !adc_rc)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (adc_cs_n && $past(!adc_cs_n && adc_rc))); // R6

    AST_TIMEOUT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_timeout) |-> (!result_valid && adc_cs_n)); // R7

    AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy); // R8

    AST_RESET_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> adc_cs_n); // R9

    AST_RESET_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_cmd && !busy) |=> adc_reset); // R9

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_data) |-> result_valid); // R10

endmodule

bind adc_seq_ctrl adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_req   (sample_req),
    .reset_cmd    (reset_cmd),
    .busy         (busy),
    .result_valid (result_valid),
    .result_data  (result_data),
    .eoc_timeout  (eoc_timeout),
    .adc_cs_n     (adc_cs_n),
    .adc_rc       (adc_rc),
    .adc_reset    (adc_reset)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    function automatic int cyc_of(input int ns);
        int t;
        t = (ns * 50 + 999) / 1000;
        return (t < 1) ? 1 : t;
    endfunction

    localparam int CS_LOW  = cyc_of(60);
    localparam int ACQ     = cyc_of(200);
    localparam int WAKE    = 1 * 50;
    localparam int DV      = cyc_of(60);
    localparam int RSTW    = cyc_of(100);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_req = 1'b0;
    logic        shutdown_sel = 1'b0;
    logic        reset_cmd = 1'b0;
    logic        busy, result_valid, eoc_timeout;
    logic [15:0] result_data;
    logic        adc_cs_n, adc_rc, adc_reset;
    logic        adc_eoc_n = 1'b1;
    logic [15:0] model_data = 16'h0000;
    wire  [15:0] adc_data;

    assign adc_data = (!adc_cs_n && adc_rc) ? model_data : 16'hzzzz;

    always #10 clk = ~clk;

    adc_seq_ctrl #(
        .CLK_MHZ(50), .CS_LOW_NS(60), .CS_HIGH_NS(40), .ACQ_NS(200),
        .WAKE_US(1), .EOC_TMO_NS(2000), .DV_NS(60), .RST_NS(100)
    ) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_req(sample_req),
        .shutdown_sel(shutdown_sel), .reset_cmd(reset_cmd), .busy(busy),
        .result_valid(result_valid), .result_data(result_data),
        .eoc_timeout(eoc_timeout), .adc_cs_n(adc_cs_n), .adc_rc(adc_rc),
        .adc_reset(adc_reset), .adc_eoc_n(adc_eoc_n), .adc_data(adc_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- converter model and edge monitor (negedge sampling)
    int   cyc = 0, phase = 0, t_fall = 0, t_first = 0, eoc_at = -1;
    int   conv_delay = 5, exp_gap = 0, first_falls = 0;
    int   rst_run = 0, last_rst_w = 0;
    bit   exp_mode = 1'b0, exp_wake = 1'b1, exp_shut = 1'b1;
    logic prev_cs = 1'b1, prev_err = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !adc_cs_n) begin
                t_fall = cyc;
                if (phase == 0) begin
                    first_falls++;
                    chk(adc_rc == 1'b0, "R2 rc at first fall", int'(adc_rc), 0);
                    t_first = cyc;
                    phase = 1;
                end else if (phase == 1) begin
                    chk(cyc - t_first == exp_gap, exp_wake ? "R5 wake gap" : "R3 acq gap",
                        cyc - t_first, exp_gap);
                    chk(adc_rc == exp_mode, "R4 rc at second fall", int'(adc_rc), int'(exp_mode));
                    eoc_at = (conv_delay < 0) ? -1 : cyc + conv_delay;
                    phase = 2;
                end else begin
                    chk(adc_rc == 1'b1, "R6 rc during read", int'(adc_rc), 1);
                    phase = 3;
                end
            end
            if (!prev_cs && adc_cs_n) begin
                if (phase == 1)
                    chk(cyc - t_fall == CS_LOW, "R2 first low width", cyc - t_fall, CS_LOW);
                else if (phase == 2)
                    chk(cyc - t_fall == CS_LOW, "R4 second low width", cyc - t_fall, CS_LOW);
                else if (phase == 3) begin
                    chk(cyc - t_fall == DV, "R6 read low width", cyc - t_fall, DV);
                    adc_eoc_n = 1'b1;
                    phase = 0;
                end
            end
            if (eoc_at >= 0 && cyc == eoc_at) adc_eoc_n = 1'b0;
            if (eoc_timeout && !prev_err) begin
                phase = 0;
                eoc_at = -1;
            end
            if (adc_reset) begin
                rst_run++;
                if (!adc_cs_n) chk(1'b0, "R9 cs low during reset", 0, 1);
            end else if (rst_run != 0) begin
                last_rst_w = rst_run;
                rst_run = 0;
            end
        end
        prev_cs  = adc_cs_n;
        prev_err = eoc_timeout;
    end

    // ---------------- stimulus tasks
    task automatic run_conv(input bit mode, input logic [15:0] pat, input int dly,
                            input bit spam, input bit clears_err);
        bit got = 1'b0;
        while (busy) @(negedge clk);
        model_data = pat;
        conv_delay = dly;
        exp_mode   = mode;
        exp_wake   = exp_shut;
        exp_gap    = CS_LOW + (exp_shut ? WAKE : ACQ);
        shutdown_sel = mode;
        sample_req = 1'b1;
        @(negedge clk);
        sample_req = spam;
        chk(busy == 1'b1, "R8 busy after request", int'(busy), 1);
        if (clears_err)
            chk(eoc_timeout == 1'b0, "R7 error cleared by request", int'(eoc_timeout), 0);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (result_valid) begin
                got = 1'b1;
                sample_req = 1'b0;
                chk(result_data == pat, "R6 result word", int'(result_data), int'(pat));
                chk(adc_cs_n == 1'b1, "R6 cs high with valid", int'(adc_cs_n), 1);
                @(negedge clk);
                chk(result_valid == 1'b0, "R6 valid one cycle", int'(result_valid), 0);
                break;
            end
            if (eoc_timeout) break;
        end
        sample_req = 1'b0;
        if (dly < 0) begin
            chk(got == 1'b0, "R7 no valid on timeout", int'(got), 0);
            chk(eoc_timeout == 1'b1, "R7 timeout flag", int'(eoc_timeout), 1);
            chk(adc_cs_n == 1'b1, "R7 cs high after timeout", int'(adc_cs_n), 1);
            exp_shut = 1'b1;
        end else begin
            chk(got == 1'b1, "R6 valid seen", int'(got), 1);
            chk(eoc_timeout == 1'b0, "R6 no timeout", int'(eoc_timeout), 0);
            exp_shut = mode;
        end
        // R10: result holds between strobes
        for (int i = 0; i < 4; i++) begin
            logic [15:0] held;
            held = result_data;
            @(negedge clk);
            chk(result_data == held, "R10 result held", int'(result_data), int'(held));
        end
    endtask

    initial begin : main
        logic [15:0] pat;
        int          dlys[4] = '{1, 7, 30, 85};
        int          base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 cs idle", int'(adc_cs_n), 1);
        chk(adc_rc == 1'b0, "R1 rc idle", int'(adc_rc), 0);
        chk(adc_reset == 1'b0, "R1 reset idle", int'(adc_reset), 0);
        chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);
        chk(result_valid == 1'b0, "R1 valid idle", int'(result_valid), 0);
        chk(eoc_timeout == 1'b0, "R1 error idle", int'(eoc_timeout), 0);

        // Sweep modes (every previous/next pairing), delays and word patterns.
        for (int i = 0; i < 16; i++) begin
            bit m;
            m = bit'((16'h3A6C >> i) & 1);
            pat = 16'(i * 16'h1357) ^ 16'hA5A5;
            if (i == 3) pat = 16'hFFFF;
            if (i == 4) pat = 16'h0000;
            run_conv(m, pat, dlys[i % 4], 1'b0, 1'b0);
        end

        // R8: requests during busy are dropped
        base = first_falls;
        run_conv(1'b0, 16'h1234, 20, 1'b1, 1'b0);
        repeat (30) @(negedge clk);
        chk(first_falls - base == 1, "R8 requests while busy dropped", first_falls - base, 1);

        // R7: timeout, then recovery with wake gap (R5)
        run_conv(1'b0, 16'hDEAD, 10, 1'b0, 1'b0);
        run_conv(1'b0, 16'hBEEF, -1, 1'b0, 1'b0);
        run_conv(1'b0, 16'h5AA5, 12, 1'b0, 1'b1);

        // R9: reset command with priority over a simultaneous request
        while (busy) @(negedge clk);
        base = first_falls;
        reset_cmd = 1'b1;
        sample_req = 1'b1;
        @(negedge clk);
        reset_cmd = 1'b0;
        sample_req = 1'b0;
        chk(adc_reset == 1'b1, "R9 reset asserted", int'(adc_reset), 1);
        while (busy) @(negedge clk);
        chk(last_rst_w == RSTW, "R9 reset width", last_rst_w, RSTW);
        chk(first_falls == base, "R9 request ignored with reset", first_falls - base, 0);
        exp_shut = 1'b1;
        run_conv(1'b0, 16'h0F0F, 3, 1'b0, 1'b0);
        run_conv(1'b0, 16'hF0F0, 60, 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule